// File: doc/BRIEF.md
# Receive Acknowledge Selector

This block decides which acknowledge code the link layer returns for each asynchronous packet it receives from the serial bus. A packet parser upstream presents the decoded header fields, the CRC verdicts and the buffer state for one cycle with `pktValid`. One cycle later the block raises `ackValid` for a single cycle with a 4-bit code, or stays silent when the packet must not be acknowledged.

The verdict depends on several inputs. The destination offset is compared against a programmable physical bound, which splits the space into a low physical window, a middle window handed to software, and the top 4 GB register window. A write in the low window that the physical engine takes can be completed at once as a posted write, but only while posted-write credit remains. The block keeps that credit itself: it counts posted completions it has issued and releases one credit for each done pulse from the write engine. When a packet cannot be taken, the busy code follows the retry mode and the packet's retry field.

Top module: `rxack_sel`

## Requirements
- R1: No acknowledge is produced for a packet received while `isoPhase` is high, for a packet with a bad header CRC, for a write with `broadcast` high, or for a transaction code outside the set {0x0 write quadlet, 0x1 write block, 0x2 write response, 0x4 read quadlet, 0x5 read block, 0x6 read quadlet response, 0x7 read block response, 0x9 lock, 0xB lock response}.
- R2: `ackValid` is high for exactly the cycle after the cycle in which `pktValid` was high, and only when that packet earns an acknowledge. After reset `ackValid` is low.
- R3: A response (tcode 0x2, 0x6, 0x7 or 0xB) with good CRCs is answered complete (0x1) when `bufRoom` is high, and busy otherwise.
- R4: A write whose offset is below `physUpperBound` is posted and answered complete (0x1) when `physEligible` and `postedEn` are both high and fewer than `POST_LIMIT` posted writes are outstanding. Each posted completion adds one to `postedCount`.
- R5: A write that the physical engine takes (offset below the bound and `physEligible` high) but that cannot be posted is answered pending (0x2), whatever the buffer state.
- R6: Any other write is answered complete (0x1) at offsets up to 0xFFFE_FFFF_FFFF and pending (0x2) at offsets from 0xFFFF_0000_0000 upward, provided `bufRoom` is high. Otherwise it is answered busy.
- R7: Reads and locks are answered pending (0x2) when `bufRoom` is high, and busy otherwise. A block request (tcode 0x1, 0x5 or 0x9) with a non-zero extended tcode is handled the same way.
- R8: A packet with a good header CRC but a bad data CRC, or with `dataLenOk` low, is answered busy. This check comes before every rule except R1.
- R9: The busy code is busy_X (0x4) when `dualPhase` is low. When `dualPhase` is high, `rtCode` 2'b10 gives busy_A (0x5), 2'b11 gives busy_B (0x6), and any other value gives busy_X.
- R10: A block write with extended tcode 0 whose `dataLen` exceeds 2^(`maxRec`+1) bytes, and which the physical engine does not take, is answered type_error (0xE). The physical path has priority over this rule.
- R11: Each `postDone` pulse takes one from `postedCount`, never going below 0. A posted completion in the same cycle as a `postDone` pulse leaves the count unchanged. The count never exceeds `POST_LIMIT`, and reset clears it to 0.
- R12: The only codes ever issued are 0x1, 0x2, 0x4, 0x5, 0x6 and 0xE. The data-error code is never issued.
- R13: The low physical window ends at the value on `physUpperBound`. Moving it moves the point where writes stop being physical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| pktValid | input | 1 | Received packet fields are valid this cycle |
| tcode | input | 4 | Transaction code |
| extTcode | input | 16 | Extended transaction code |
| destOffset | input | 48 | Destination offset |
| dataLen | input | 16 | Payload length in bytes |
| maxRec | input | 4 | Largest accepted block payload, as 2^(maxRec+1) bytes |
| rtCode | input | 2 | Retry field of the packet |
| hdrCrcOk | input | 1 | Header CRC good |
| dataCrcOk | input | 1 | Data CRC good, or no data block |
| dataLenOk | input | 1 | Payload length consistent |
| bufRoom | input | 1 | Receive buffer can hold the whole packet |
| physEligible | input | 1 | Physical engine accepts this request |
| postedEn | input | 1 | Posted writes enabled |
| dualPhase | input | 1 | Dual-phase retry mode selected |
| isoPhase | input | 1 | Bus is in the isochronous phase |
| broadcast | input | 1 | Packet is a broadcast |
| physUpperBound | input | 48 | End (exclusive) of the physical window |
| postDone | input | 1 | Write engine finished one posted write |
| ackValid | output | 1 | Acknowledge strobe |
| ackCode | output | 4 | Acknowledge code |
| postedCount | output | 3 | Outstanding posted writes |

## Verification
The checker watches several rules on every cycle. It checks that an acknowledge only ever follows a packet strobe. It checks that the isochronous phase and bad header CRCs always silence the output, and that the code stays inside the legal set. It checks that busy_A and busy_B never appear in single-phase mode. It checks that the posted count stays within its limit, changes by at most one per cycle, never rises after a done pulse, and rises only together with a complete acknowledge. The rest needs the bench's scenarios: the address partition and its move with the programmable bound, the type_error and length boundary, the busy selection by retry field, credit exhaustion, and a done pulse that coincides with a posted write.

// File: rtl/rxack_pkg.sv
package rxack_pkg;

  typedef enum logic [3:0] {
    ACK_NONE    = 4'h0,
    ACK_DONE    = 4'h1,
    ACK_PEND    = 4'h2,
    ACK_BUSYX   = 4'h4,
    ACK_BUSYA   = 4'h5,
    ACK_BUSYB   = 4'h6,
    ACK_TYPEERR = 4'hE
  } ackCodeT;

  localparam logic [3:0] TC_WRQ  = 4'h0;
  localparam logic [3:0] TC_WRB  = 4'h1;
  localparam logic [3:0] TC_WRSP = 4'h2;
  localparam logic [3:0] TC_RDQ  = 4'h4;
  localparam logic [3:0] TC_RDB  = 4'h5;
  localparam logic [3:0] TC_RQSP = 4'h6;
  localparam logic [3:0] TC_RBSP = 4'h7;
  localparam logic [3:0] TC_LCK  = 4'h9;
  localparam logic [3:0] TC_LRSP = 4'hB;

  // flags decoded by the datapath for the control
  typedef struct packed {
    logic isResp;
    logic isWrite;
    logic isBlockWrite;
    logic isRdLock;
    logic isBlockReq;
    logic extNz;
    logic inPhys;
    logic inTop;
    logic overLen;
    logic postCredit;
  } dpFlagsT;

  // strobes from the control to the datapath
  typedef struct packed {
    logic postInc;
  } ctlStrobeT;

endpackage

// File: rtl/rxack_datapath.sv
module rxack_datapath
  import rxack_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int LEN_W      = 16,
  parameter int EXT_W      = 16,
  parameter int TOP_W      = 16,
  parameter int POST_LIMIT = 4,
  localparam int CNT_W     = $clog2(POST_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [3:0]        tcode,
  input  logic [EXT_W-1:0]  extTcode,
  input  logic [ADDR_W-1:0] destOffset,
  input  logic [LEN_W-1:0]  dataLen,
  input  logic [3:0]        maxRec,
  input  logic [ADDR_W-1:0] physUpperBound,
  input  logic              postDone,
  input  ctlStrobeT         strobe,
  output dpFlagsT           flags,
  output logic [CNT_W-1:0]  postedCount
);

  localparam int LIM_W = LEN_W + 2;
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(POST_LIMIT);

  logic [LIM_W-1:0] recLimit;
  logic [4:0]       recShift;

  always_comb begin
    recShift = {1'b0, maxRec} + 5'd1;
    recLimit = LIM_W'(1) << recShift;
  end

  always_comb begin
    flags.isResp       = (tcode == TC_WRSP) || (tcode == TC_RQSP) ||
                         (tcode == TC_RBSP) || (tcode == TC_LRSP);
    flags.isWrite      = (tcode == TC_WRQ) || (tcode == TC_WRB);
    flags.isBlockWrite = (tcode == TC_WRB) && (extTcode == '0);
    flags.isRdLock     = (tcode == TC_RDQ) || (tcode == TC_RDB) || (tcode == TC_LCK);
    flags.isBlockReq   = (tcode == TC_WRB) || (tcode == TC_RDB) || (tcode == TC_LCK);
    flags.extNz        = (extTcode != '0);
    flags.inPhys       = (destOffset < physUpperBound);
    flags.inTop        = &destOffset[ADDR_W-1 -: TOP_W];
    flags.overLen      = ({{(LIM_W-LEN_W){1'b0}}, dataLen} > recLimit);
    flags.postCredit   = (postedCount < CNT_MAX);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      postedCount <= '0;
    end else begin
      unique case ({strobe.postInc, postDone})
        2'b10:   if (postedCount < CNT_MAX) postedCount <= postedCount + 1'b1;
        2'b01:   if (postedCount != '0)     postedCount <= postedCount - 1'b1;
        default: postedCount <= postedCount;
      endcase
    end
  end

endmodule

// File: rtl/rxack_control.sv
module rxack_control
  import rxack_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pktValid,
  input  logic [1:0] rtCode,
  input  logic       hdrCrcOk,
  input  logic       dataCrcOk,
  input  logic       dataLenOk,
  input  logic       bufRoom,
  input  logic       physEligible,
  input  logic       postedEn,
  input  logic       dualPhase,
  input  logic       isoPhase,
  input  logic       broadcast,
  input  dpFlagsT    flags,
  output ctlStrobeT  strobe,
  output logic       ackValid,
  output logic [3:0] ackCode
);

  ackCodeT busyCode;
  ackCodeT nextCode;
  logic    physPath;
  logic    silent;

  always_comb begin
    busyCode = ACK_BUSYX;
    if (dualPhase) begin
      if (rtCode == 2'b10)      busyCode = ACK_BUSYA;
      else if (rtCode == 2'b11) busyCode = ACK_BUSYB;
    end
  end

  always_comb begin
    physPath = physEligible && flags.inPhys;
    silent   = !pktValid || isoPhase || !hdrCrcOk || (broadcast && flags.isWrite) ||
               !(flags.isResp || flags.isWrite || flags.isRdLock);
    nextCode       = ACK_NONE;
    strobe.postInc = 1'b0;
    if (!silent) begin
      if (!dataCrcOk || !dataLenOk) begin
        nextCode = busyCode;
      end else if (flags.isResp) begin
        nextCode = bufRoom ? ACK_DONE : busyCode;
      end else if (flags.isBlockReq && flags.extNz) begin
        nextCode = bufRoom ? ACK_PEND : busyCode;
      end else if (flags.isBlockWrite && flags.overLen && !physPath) begin
        nextCode = ACK_TYPEERR;
      end else if (flags.isWrite && physPath) begin
        if (postedEn && flags.postCredit) begin
          nextCode       = ACK_DONE;
          strobe.postInc = 1'b1;
        end else begin
          nextCode = ACK_PEND;
        end
      end else if (flags.isWrite) begin
        nextCode = !bufRoom ? busyCode : (flags.inTop ? ACK_PEND : ACK_DONE);
      end else begin
        nextCode = bufRoom ? ACK_PEND : busyCode;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ackValid <= 1'b0;
      ackCode  <= 4'h0;
    end else begin
      ackValid <= (nextCode != ACK_NONE);
      ackCode  <= nextCode;
    end
  end

endmodule

// File: rtl/rxack_sel.sv
module rxack_sel
  import rxack_pkg::*;
#(
  parameter int ADDR_W     = 48,
  parameter int LEN_W      = 16,
  parameter int EXT_W      = 16,
  parameter int POST_LIMIT = 4,
  localparam int CNT_W     = $clog2(POST_LIMIT + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pktValid,
  input  logic [3:0]        tcode,
  input  logic [EXT_W-1:0]  extTcode,
  input  logic [ADDR_W-1:0] destOffset,
  input  logic [LEN_W-1:0]  dataLen,
  input  logic [3:0]        maxRec,
  input  logic [1:0]        rtCode,
  input  logic              hdrCrcOk,
  input  logic              dataCrcOk,
  input  logic              dataLenOk,
  input  logic              bufRoom,
  input  logic              physEligible,
  input  logic              postedEn,
  input  logic              dualPhase,
  input  logic              isoPhase,
  input  logic              broadcast,
  input  logic [ADDR_W-1:0] physUpperBound,
  input  logic              postDone,
  output logic              ackValid,
  output logic [3:0]        ackCode,
  output logic [CNT_W-1:0]  postedCount
);

  dpFlagsT   flags;
  ctlStrobeT strobe;

  rxack_datapath #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .EXT_W(EXT_W), .TOP_W(16), .POST_LIMIT(POST_LIMIT)
  ) dp (
    .clk(clk), .rstN(rstN), .tcode(tcode), .extTcode(extTcode),
    .destOffset(destOffset), .dataLen(dataLen), .maxRec(maxRec),
    .physUpperBound(physUpperBound), .postDone(postDone), .strobe(strobe),
    .flags(flags), .postedCount(postedCount)
  );

  rxack_control ctl (
    .clk(clk), .rstN(rstN), .pktValid(pktValid), .rtCode(rtCode),
    .hdrCrcOk(hdrCrcOk), .dataCrcOk(dataCrcOk), .dataLenOk(dataLenOk),
    .bufRoom(bufRoom), .physEligible(physEligible), .postedEn(postedEn),
    .dualPhase(dualPhase), .isoPhase(isoPhase), .broadcast(broadcast),
    .flags(flags), .strobe(strobe), .ackValid(ackValid), .ackCode(ackCode)
  );

endmodule

// File: rtl/rxack_sel_checker.sv
module rxack_sel_checker #(
  parameter int POST_LIMIT = 4,
  localparam int CNT_W     = $clog2(POST_LIMIT + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             pktValid,
  input logic             isoPhase,
  input logic             hdrCrcOk,
  input logic             dualPhase,
  input logic             postDone,
  input logic             ackValid,
  input logic [3:0]       ackCode,
  input logic [CNT_W-1:0] postedCount
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(POST_LIMIT);

  a_r2_ack_follows_pkt: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> $past(pktValid));

  a_r1_iso_silent: assert property (@(posedge clk) disable iff (!rstN)
    pktValid && isoPhase |=> !ackValid);

  a_r1_bad_hdr_silent: assert property (@(posedge clk) disable iff (!rstN)
    pktValid && !hdrCrcOk |=> !ackValid);

  a_r12_legal_code: assert property (@(posedge clk) disable iff (!rstN)
    ackValid |-> (ackCode == 4'h1 || ackCode == 4'h2 || ackCode == 4'h4 ||
                  ackCode == 4'h5 || ackCode == 4'h6 || ackCode == 4'hE));

  a_r9_single_phase_busyx: assert property (@(posedge clk) disable iff (!rstN)
    ackValid && $past(!dualPhase) |-> (ackCode != 4'h5 && ackCode != 4'h6));

  a_r11_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    postedCount <= CNT_MAX);

  a_r11_count_step: assert property (@(posedge clk) disable iff (!rstN)
    (postedCount == $past(postedCount)) ||
    (postedCount == $past(postedCount) + 1'b1) ||
    (postedCount == $past(postedCount) - 1'b1));

  a_r11_done_no_rise: assert property (@(posedge clk) disable iff (!rstN)
    postDone |=> postedCount <= $past(postedCount));

  a_r4_rise_with_complete: assert property (@(posedge clk) disable iff (!rstN)
    postedCount > $past(postedCount) |-> ackValid && ackCode == 4'h1);

endmodule

bind rxack_sel rxack_sel_checker #(.POST_LIMIT(POST_LIMIT)) chk (.*);

// File: tb/rxack_sel_test.sv
`timescale 1ns/1ps
module rxack_sel_test;

  typedef struct packed {
    logic [3:0]  tc;
    logic [15:0] ext;
    logic [47:0] off;
    logic [15:0] len;
    logic [1:0]  rt;
    logic        hok, dok, lok, room, phys, pen, dual, iso, bc;
    logic [3:0]  exp;   // 0 means no acknowledge
  } vecT;

  localparam int NV = 26;
  localparam logic [47:0] LOW = 48'h0000_0000_1000;
  localparam logic [47:0] MID = 48'h0002_0000_0000;
  // tc ext off len rt hok dok lok room phys pen dual iso bc exp
  localparam vecT TBL [NV] = '{
    '{4'h2, 16'h0, MID, 16'd0,    2'd0, 1,1,1,1,0,0,0,0,0, 4'h1}, // R3 response fits
    '{4'h7, 16'h0, MID, 16'd8,    2'd0, 1,1,1,0,0,0,0,0,0, 4'h4}, // R3 R9 no room single
    '{4'hB, 16'h0, MID, 16'd4,    2'd2, 1,1,1,0,0,0,1,0,0, 4'h5}, // R9 dual rt=2
    '{4'h6, 16'h0, MID, 16'd0,    2'd3, 1,1,1,0,0,0,1,0,0, 4'h6}, // R9 dual rt=3
    '{4'h2, 16'h0, MID, 16'd0,    2'd1, 1,1,1,0,0,0,1,0,0, 4'h4}, // R9 dual rt=1
    '{4'h0, 16'h0, MID, 16'd0,    2'd0, 1,1,1,1,0,0,0,1,0, 4'h0}, // R1 iso phase
    '{4'h4, 16'h0, MID, 16'd0,    2'd0, 0,1,1,1,0,0,0,0,0, 4'h0}, // R1 bad header
    '{4'h1, 16'h0, MID, 16'd8,    2'd0, 1,1,1,1,0,0,0,0,1, 4'h0}, // R1 broadcast write
    '{4'h3, 16'h0, MID, 16'd0,    2'd0, 1,1,1,1,0,0,0,0,0, 4'h0}, // R1 unknown tcode
    '{4'h4, 16'h0, MID, 16'd0,    2'd0, 1,0,1,1,0,0,0,0,0, 4'h4}, // R8 bad data crc
    '{4'h1, 16'h0, MID, 16'd8,    2'd2, 1,1,0,1,0,0,1,0,0, 4'h5}, // R8 length error
    '{4'h0, 16'h0, LOW, 16'd0,    2'd0, 1,1,1,0,1,1,0,0,0, 4'h1}, // R4 posted (cnt 1)
    '{4'h0, 16'h0, LOW, 16'd0,    2'd0, 1,1,1,0,1,0,0,0,0, 4'h2}, // R5 phys not posted
    '{4'h0, 16'h0, MID, 16'd0,    2'd0, 1,1,1,1,0,0,0,0,0, 4'h1}, // R6 middle
    '{4'h0, 16'h0, 48'hFFFF_0000_0010, 16'd0, 2'd0, 1,1,1,1,0,0,0,0,0, 4'h2}, // R6 top
    '{4'h0, 16'h0, 48'hFFFE_FFFF_FFFC, 16'd0, 2'd0, 1,1,1,1,0,0,0,0,0, 4'h1}, // R6 edge
    '{4'h0, 16'h0, MID, 16'd0,    2'd0, 1,1,1,0,0,0,0,0,0, 4'h4}, // R6 no room
    '{4'h4, 16'h0, MID, 16'd0,    2'd0, 1,1,1,1,0,0,0,0,0, 4'h2}, // R7 read
    '{4'h9, 16'h2, MID, 16'd8,    2'd0, 1,1,1,1,0,0,0,0,0, 4'h2}, // R7 lock
    '{4'h9, 16'h2, MID, 16'd8,    2'd0, 1,1,1,0,0,0,0,0,0, 4'h4}, // R7 lock no room
    '{4'h1, 16'h1, MID, 16'd8,    2'd0, 1,1,1,1,0,0,0,0,0, 4'h2}, // R7 ext nonzero
    '{4'h1, 16'h0, MID, 16'd2048, 2'd0, 1,1,1,1,0,0,0,0,0, 4'hE}, // R10 oversize
    '{4'h1, 16'h0, LOW, 16'd2048, 2'd0, 1,1,1,1,1,1,0,0,0, 4'h1}, // R10 phys wins (cnt 2)
    '{4'h1, 16'h0, MID, 16'd1024, 2'd0, 1,1,1,1,0,0,0,0,0, 4'h1}, // R10 at limit
    '{4'h0, 16'h0, 48'h0001_0000_0000, 16'd0, 2'd0, 1,1,1,0,1,1,0,0,0, 4'h4}, // R13 at bound
    '{4'h0, 16'h0, 48'h0000_FFFF_FFFC, 16'd0, 2'd0, 1,1,1,0,1,1,0,0,0, 4'h1}  // R4 below (cnt 3)
  };

  logic clk = 0, rstN = 0, pktValid = 0;
  logic [3:0] tcode = 0, maxRec = 4'd9;
  logic [15:0] extTcode = 0, dataLen = 0;
  logic [47:0] destOffset = 0, physUpperBound = 48'h0001_0000_0000;
  logic [1:0] rtCode = 0;
  logic hdrCrcOk = 0, dataCrcOk = 0, dataLenOk = 0, bufRoom = 0, physEligible = 0;
  logic postedEn = 0, dualPhase = 0, isoPhase = 0, broadcast = 0, postDone = 0;
  logic ackValid;
  logic [3:0] ackCode;
  logic [2:0] postedCount;
  int nChecks = 0, nFails = 0;

  always #2 clk = ~clk;

  rxack_sel uut (.*);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load(vecT v);
    tcode = v.tc; extTcode = v.ext; destOffset = v.off; dataLen = v.len; rtCode = v.rt;
    hdrCrcOk = v.hok; dataCrcOk = v.dok; dataLenOk = v.lok; bufRoom = v.room;
    physEligible = v.phys; postedEn = v.pen; dualPhase = v.dual; isoPhase = v.iso;
    broadcast = v.bc;
  endtask

  // called at a falling edge; checks the acknowledge one cycle later
  task automatic send(vecT v, string req, logic [3:0] exp, logic done);
    load(v);
    pktValid = 1; postDone = done;
    @(negedge clk);
    pktValid = 0; postDone = 0;
    chk({req, " valid"}, 32'(ackValid), 32'(exp != 4'h0));
    if (exp != 4'h0) chk({req, " code"}, 32'(ackCode), 32'(exp));
  endtask

  function automatic vecT wr(logic [47:0] off, logic phys, logic pen, logic room);
    vecT v = TBL[11];
    v.off = off; v.phys = phys; v.pen = pen; v.room = room;
    return v;
  endfunction

  initial begin
    #400000;
    nFails++;
    $display("FAIL R2 watchdog actual=running expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R2 reset ackValid", 32'(ackValid), 0);
    chk("R11 reset count", 32'(postedCount), 0);
    rstN = 1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) send(TBL[i], $sformatf("R-table[%0d]", i), TBL[i].exp, 0);
    chk("R4 count after table", 32'(postedCount), 3);
    @(negedge clk);
    chk("R2 strobe drops", 32'(ackValid), 0);
    send(wr(LOW, 1, 1, 0), "R4 fourth posted", 4'h1, 0);
    chk("R4 count at limit", 32'(postedCount), 4);
    send(wr(LOW, 1, 1, 0), "R5 credit exhausted", 4'h2, 0);
    chk("R11 count held at limit", 32'(postedCount), 4);
    postDone = 1; @(negedge clk); postDone = 0;
    chk("R11 done decrements", 32'(postedCount), 3);
    send(wr(LOW, 1, 1, 0), "R11 posted with done", 4'h1, 1);
    chk("R11 simultaneous holds", 32'(postedCount), 3);
    rstN = 0; @(negedge clk); @(negedge clk);
    chk("R11 reset clears", 32'(postedCount), 0);
    chk("R2 reset silences", 32'(ackValid), 0);
    rstN = 1; @(negedge clk);
    postDone = 1; @(negedge clk); postDone = 0;
    chk("R11 no underflow", 32'(postedCount), 0);
    physUpperBound = 48'h0010_0000_0000;
    send(wr(MID, 1, 0, 1), "R13 moved bound pending", 4'h2, 0);
    send(wr(MID, 1, 1, 1), "R13 moved bound posted", 4'h1, 0);
    chk("R13 count", 32'(postedCount), 1);
    send(wr(48'h0010_0000_0000, 1, 1, 1), "R13 at new bound", 4'h1, 0);
    chk("R13 not posted at bound", 32'(postedCount), 1);
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

endmodule